// File: doc/BRIEF.md
# Serial Segment-Display Command Receiver

This block is the two-wire serial slave front end of a segment display controller. It oversamples the bus clock and data lines with the system clock and finds START and STOP conditions. It then checks the first byte of each transfer against a fixed 7-bit device address and its direction bit. It acknowledges the bytes addressed to it by pulling the data line low.

After a write address, the block reads command bytes. Bit 7 of every command byte says whether the byte after it is another command or the start of display data. An address-set command loads the write pointer. Any other command goes out on a one-cycle strobe with its seven payload bits, so a neighbouring decoder can handle it.

Once display data starts, every further byte of the transfer is written into a 35-entry by 8-bit display RAM. The pointer advances after each byte and wraps from the last column back to column 0. A second, registered port reads the RAM so the segment scanner can fetch columns.

Top module: `seg_cmd_rx`

## Requirements
- R1: A first byte of 0111110 followed by direction bit 0 is acknowledged: `sda_drive_low` is 1 during the ninth clock pulse. Each following command byte and data byte of that transfer is also acknowledged.
- R2: A first byte whose upper seven bits are not 0111110 is not acknowledged. Every byte after it, up to the next START, gets no acknowledge, writes no RAM entry and raises no `cmd_valid`.
- R3: A command byte with bit 7 = 1 is followed by another command byte. A command byte with bit 7 = 0 makes every later byte of the transfer display data.
- R4: While a transfer is in data mode, a byte of any value is stored in RAM and never raises `cmd_valid`. Only a new START brings back command input.
- R5: A command byte with bits 6:5 = 00 loads the write pointer with bits 4:0 and raises no `cmd_valid`.
- R6: Any other command byte raises `cmd_valid` for exactly one clock, with `cmd_payload` equal to bits 6:0 of that byte.
- R7: A data byte is stored at the write pointer. The bit received first (the COM0 row) lands in `rd_data[7]` and the bit received last (COM7) lands in `rd_data[0]`.
- R8: After each stored data byte the pointer advances by one, and after address 34 (22h) it wraps to address 0.
- R9: A START or STOP that arrives before the eighth bit of a byte is complete cancels that byte. A cancelled command raises no `cmd_valid`, and a cancelled data byte writes nothing.
- R10: A first byte of 0111110 followed by direction bit 1 is acknowledged. After that the block leaves the data line released, so the master reads 0xFF.
- R11: While `rst` is high and on the clock after it, `sda_drive_low` and `cmd_valid` are 0.
- R12: `rd_data` shows the RAM entry at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Serial clock line as seen on the pin |
| sda_in | input | 1 | Serial data line as seen on the pin |
| sda_drive_low | output | 1 | 1 pulls the data line low (acknowledge) |
| cmd_valid | output | 1 | One-clock strobe for a command other than address-set |
| cmd_payload | output | 7 | Bits 6:0 of the strobed command byte |
| rd_addr | input | 6 | Display RAM read address |
| rd_data | output | 8 | Display RAM read data, bit 7 = COM0 |

## Verification
Each line passes two synchronizer flops and one edge register. The registered outputs therefore change about four clocks after the bus edge that causes them. The acknowledge, the command strobe and the RAM write all follow the falling clock edge that ends the eighth bit. The bench holds each bus level for 20 clocks and reads `sda_drive_low` in the middle of the ninth high phase, well past that settling time. RAM contents are read only after the transfer ends: the bench applies `rd_addr` at a falling clock edge and compares `rd_data` at the next falling edge, one register later.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CMD  = 3'd2,
    PH_DATA = 3'd3,
    PH_READ = 3'd4,
    PH_SKIP = 3'd5
  } phase_t;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/seg_bus_sync.sv
module seg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_s;

  // Each line passes its own chain of synchronizer flops.
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_prev;
  assign scl_fall = ~scl_s & scl_prev;
  // A data edge while the clock stays high marks a bus condition.
  assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/seg_cmd_decode.sv
module seg_cmd_decode
  import seg_rx_pkg::*;
#(
  parameter int         DEPTH      = 35,
  parameter int         AW         = 6,
  parameter logic [6:0] SLAVE_ADDR = 7'b0111110
) (
  input  phase_t          phase,
  input  logic [7:0]      rx_byte,
  input  logic [AW-1:0]   ptr,
  output logic            ack,
  output phase_t          phase_nxt,
  output logic [AW-1:0]   ptr_nxt,
  output logic            wr_req,
  output logic            cmd_req
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_comb begin
    ack       = 1'b0;
    phase_nxt = phase;
    ptr_nxt   = ptr;
    wr_req    = 1'b0;
    cmd_req   = 1'b0;
    case (phase)
      PH_ADDR: begin
        if (rx_byte[7:1] == SLAVE_ADDR) begin
          ack       = 1'b1;
          phase_nxt = rx_byte[0] ? PH_READ : PH_CMD;
        end else begin
          phase_nxt = PH_SKIP;
        end
      end
      PH_CMD: begin
        ack       = 1'b1;
        phase_nxt = rx_byte[7] ? PH_CMD : PH_DATA;
        if (rx_byte[6:5] == 2'b00) begin
          ptr_nxt = AW'(rx_byte[4:0]);
        end else begin
          cmd_req = 1'b1;
        end
      end
      PH_DATA: begin
        ack     = 1'b1;
        wr_req  = (ptr <= LAST);
        ptr_nxt = (ptr >= LAST) ? '0 : ptr + 1'b1;
      end
      default: begin
        ack = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/seg_rx_engine.sv
module seg_rx_engine
  import seg_rx_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  // decision from the decoder
  input  logic          dec_ack,
  input  phase_t        dec_phase,
  input  logic [AW-1:0] dec_ptr,
  input  logic          dec_wr,
  input  logic          dec_cmd,
  output phase_t        phase,
  output logic [7:0]    rx_byte,
  output logic [AW-1:0] ptr,
  output logic          sda_drive_low,
  output logic          cmd_valid,
  output logic [6:0]    cmd_payload,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);

  logic [3:0] bit_cnt;
  logic       in_ack;
  logic       active;
  logic       byte_done;

  assign active    = (phase == PH_ADDR) || (phase == PH_CMD) ||
                     (phase == PH_DATA) || (phase == PH_READ);
  assign byte_done = (bit_cnt == 4'(BYTE_BITS)) && !in_ack;

  always_ff @(posedge clk) begin
    cmd_valid <= 1'b0;
    wr_en     <= 1'b0;
    if (rst) begin
      phase         <= PH_IDLE;
      bit_cnt       <= '0;
      rx_byte       <= '0;
      in_ack        <= 1'b0;
      ptr           <= '0;
      sda_drive_low <= 1'b0;
      cmd_payload   <= '0;
      wr_addr       <= '0;
      wr_data       <= '0;
    end else if (start_ev) begin
      phase         <= PH_ADDR;
      bit_cnt       <= '0;
      in_ack        <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (stop_ev) begin
      phase         <= PH_IDLE;
      bit_cnt       <= '0;
      in_ack        <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (active) begin
      if (scl_rise && bit_cnt < 4'(BYTE_BITS)) begin
        rx_byte <= {rx_byte[6:0], sda_s};
        bit_cnt <= bit_cnt + 4'd1;
      end
      if (scl_fall) begin
        if (in_ack) begin
          // ninth pulse over: release the line and start the next byte
          in_ack        <= 1'b0;
          sda_drive_low <= 1'b0;
          bit_cnt       <= '0;
        end else if (byte_done) begin
          in_ack        <= 1'b1;
          sda_drive_low <= dec_ack;
          phase         <= dec_phase;
          ptr           <= dec_ptr;
          if (dec_wr) begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= rx_byte;
          end
          if (dec_cmd) begin
            cmd_valid   <= 1'b1;
            cmd_payload <= rx_byte[6:0];
          end
        end
      end
    end
  end

endmodule

// File: rtl/seg_disp_ram.sv
module seg_disp_ram #(
  parameter int DEPTH = 35,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/seg_cmd_rx.sv
module seg_cmd_rx
  import seg_rx_pkg::*;
#(
  parameter int         DEPTH       = 35,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_ADDR  = 7'b0111110,
  parameter int         AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_drive_low,
  output logic          cmd_valid,
  output logic [6:0]    cmd_payload,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_ev;
  logic          stop_ev;
  phase_t        phase;
  logic [7:0]    rx_byte;
  logic [AW-1:0] ptr;
  logic          dec_ack;
  phase_t        dec_phase;
  logic [AW-1:0] dec_ptr;
  logic          dec_wr;
  logic          dec_cmd;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  seg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  seg_cmd_decode #(
    .DEPTH      (DEPTH),
    .AW         (AW),
    .SLAVE_ADDR (SLAVE_ADDR)
  ) u_dec (
    .phase     (phase),
    .rx_byte   (rx_byte),
    .ptr       (ptr),
    .ack       (dec_ack),
    .phase_nxt (dec_phase),
    .ptr_nxt   (dec_ptr),
    .wr_req    (dec_wr),
    .cmd_req   (dec_cmd)
  );

  seg_rx_engine #(.AW(AW)) u_eng (
    .clk           (clk),
    .rst           (rst),
    .sda_s         (sda_s),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .dec_ack       (dec_ack),
    .dec_phase     (dec_phase),
    .dec_ptr       (dec_ptr),
    .dec_wr        (dec_wr),
    .dec_cmd       (dec_cmd),
    .phase         (phase),
    .rx_byte       (rx_byte),
    .ptr           (ptr),
    .sda_drive_low (sda_drive_low),
    .cmd_valid     (cmd_valid),
    .cmd_payload   (cmd_payload),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data)
  );

  seg_disp_ram #(.DEPTH(DEPTH), .AW(AW), .DW(8)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/seg_cmd_rx_chk.sv
module seg_cmd_rx_chk (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic sda_drive_low,
  input logic cmd_valid
);

  // R1: the acknowledge drive only begins while the bus clock is low
  assert_ack_starts_low_clock_R1: assert property (
    @(posedge clk) disable iff (rst) $rose(sda_drive_low) |-> !scl_in);

  // R1: the drive never moves while the bus clock is held high
  assert_ack_stable_high_clock_R1: assert property (
    @(posedge clk) disable iff (rst) (scl_in && $past(scl_in)) |-> $stable(sda_drive_low));

  // R3: a strobed command is always acknowledged
  assert_cmd_acked_R3: assert property (
    @(posedge clk) disable iff (rst) cmd_valid |-> sda_drive_low);

  // R6: the command strobe lasts one clock
  assert_cmd_single_pulse_R6: assert property (
    @(posedge clk) disable iff (rst) cmd_valid |=> !cmd_valid);

  // R6: a command completes on a low bus clock
  assert_cmd_on_low_clock_R6: assert property (
    @(posedge clk) disable iff (rst) cmd_valid |-> !scl_in);

  // R11: reset leaves the outputs quiet
  assert_reset_idle_R11: assert property (
    @(posedge clk) rst |=> (!sda_drive_low && !cmd_valid));

endmodule

bind seg_cmd_rx seg_cmd_rx_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_in        (scl_in),
  .sda_drive_low (sda_drive_low),
  .cmd_valid     (cmd_valid)
);

// File: tb/sim_seg_cmd_rx.sv
module sim_seg_cmd_rx;

  localparam int HALF = 20;
  localparam logic [7:0] WR_ADDR = 8'h7C;
  localparam logic [7:0] RD_ADDR = 8'h7D;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_drive_low;
  logic       cmd_valid;
  logic [6:0] cmd_payload;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  wire        sda_line = m_sda & ~sda_drive_low;

  int n_checks = 0;
  int n_fail   = 0;
  int cmd_cnt  = 0;
  logic [6:0] last_payload = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_cmd_rx u0 (
    .clk           (clk),
    .rst           (rst),
    .scl_in        (m_scl),
    .sda_in        (sda_line),
    .sda_drive_low (sda_drive_low),
    .cmd_valid     (cmd_valid),
    .cmd_payload   (cmd_payload),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data)
  );

  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      cmd_cnt++;
      last_payload = cmd_payload;
    end
  end

  // stimulus: {start address, data byte}
  localparam logic [12:0] VEC [0:5] = '{
    {5'd0,  8'h80}, {5'd1,  8'h01}, {5'd7,  8'h5A},
    {5'd16, 8'hFF}, {5'd30, 8'h00}, {5'd3,  8'hC7}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hold();
      m_scl = 1'b1; hold();
      m_scl = 1'b0;
    end
  endtask

  // full byte plus the acknowledge pulse; returns the line value seen
  task automatic send_byte(input logic [7:0] b, output logic acked, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold();
      m_scl = 1'b1;
      repeat (HALF / 2) @(negedge clk);
      seen[i] = sda_line;
      repeat (HALF - HALF / 2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; hold();
    m_scl = 1'b1;
    repeat (HALF / 2) @(negedge clk);
    acked = sda_drive_low;
    repeat (HALF - HALF / 2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic read_ram(input int a, output logic [7:0] v);
    @(negedge clk) rd_addr = 6'(a);
    @(negedge clk) v = rd_data;
  endtask

  task automatic expect_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    logic [7:0] s;
    send_byte(b, a, s);
    check(a == exp_ack, req, int'(a), int'(exp_ack));
  endtask

  task automatic expect_ram(input int a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    read_ram(a, v);
    check(v == exp, req, int'(v), int'(exp));
  endtask

  initial begin
    logic a;
    logic [7:0] s;
    int c0;

    repeat (3) @(negedge clk);
    check(sda_drive_low == 1'b0, "R11 ack idle in reset", int'(sda_drive_low), 0);
    check(cmd_valid == 1'b0, "R11 strobe idle in reset", int'(cmd_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sda_drive_low == 1'b0 && cmd_valid == 1'b0, "R11 after reset",
          int'({sda_drive_low, cmd_valid}), 0);

    // vector table: address-set (R5), one data byte (R7), registered read (R12)
    foreach (VEC[k]) begin
      bus_start();
      expect_byte(WR_ADDR, 1'b1, "R1 address ack");
      expect_byte({3'b000, VEC[k][12:8]}, 1'b1, "R1 R5 address-set ack");
      expect_byte(VEC[k][7:0], 1'b1, "R1 data ack");
      bus_stop();
      expect_ram(int'(VEC[k][12:8]), VEC[k][7:0], "R7 R12 stored byte");
    end
    check(cmd_cnt == 0, "R5 address-set raises no strobe", cmd_cnt, 0);

    // R3, R4, R6: command chain then data mode
    bus_start();
    expect_byte(WR_ADDR, 1'b1, "R1 address ack");
    expect_byte(8'h85, 1'b1, "R3 set ptr 5 continue");
    expect_byte(8'hC3, 1'b1, "R3 command continue");
    check(cmd_cnt == 1 && last_payload == 7'h43, "R6 first strobe payload",
          int'(last_payload), 'h43);
    expect_byte(8'h20, 1'b1, "R3 last command");
    check(cmd_cnt == 2 && last_payload == 7'h20, "R6 second strobe payload",
          int'(last_payload), 'h20);
    expect_byte(8'h81, 1'b1, "R4 data ack");
    expect_byte(8'hC0, 1'b1, "R4 data ack");
    bus_stop();
    check(cmd_cnt == 2, "R4 data bytes raise no strobe", cmd_cnt, 2);
    expect_ram(5, 8'h81, "R4 R8 first data");
    expect_ram(6, 8'hC0, "R4 R8 second data");

    // R8: wrap from 34 to 0
    bus_start();
    expect_byte(WR_ADDR, 1'b1, "R1 address ack");
    expect_byte(8'h1F, 1'b1, "R5 set ptr 31");
    for (int i = 0; i < 5; i++) expect_byte(8'h10 + 8'(i), 1'b1, "R8 stream ack");
    bus_stop();
    expect_ram(34, 8'h13, "R8 last column");
    expect_ram(0, 8'h14, "R8 wrapped to 0");

    // R2: foreign address, then bytes are ignored
    bus_start();
    expect_byte(8'h7A, 1'b0, "R2 no ack on foreign address");
    expect_byte(8'h05, 1'b0, "R2 no ack after mismatch");
    expect_byte(8'hEE, 1'b0, "R2 no ack after mismatch");
    expect_byte(8'hC3, 1'b0, "R2 no ack after mismatch");
    bus_stop();
    expect_ram(5, 8'h81, "R2 RAM untouched");
    check(cmd_cnt == 2, "R2 no strobe", cmd_cnt, 2);
    bus_start();
    expect_byte(WR_ADDR, 1'b1, "R2 START restores");
    bus_stop();

    // R9: START in the middle of a command byte
    c0 = cmd_cnt;
    bus_start();
    expect_byte(WR_ADDR, 1'b1, "R1 address ack");
    send_bits(8'h40, 5);
    bus_start();
    check(cmd_cnt == c0, "R9 cancelled command", cmd_cnt, c0);
    expect_byte(WR_ADDR, 1'b1, "R9 address after restart");
    expect_byte(8'h0C, 1'b1, "R9 set ptr 12");
    expect_byte(8'h77, 1'b1, "R9 data");
    bus_stop();
    expect_ram(12, 8'h77, "R9 setup write");
    // STOP in the middle of a data byte
    bus_start();
    expect_byte(WR_ADDR, 1'b1, "R1 address ack");
    expect_byte(8'h0C, 1'b1, "R9 set ptr 12");
    send_bits(8'h00, 4);
    bus_stop();
    expect_ram(12, 8'h77, "R9 cancelled data byte");

    // R10: read address acked, data line released
    bus_start();
    expect_byte(RD_ADDR, 1'b1, "R10 read address ack");
    send_byte(8'hFF, a, s);
    check(s == 8'hFF, "R10 read data", int'(s), 'hFF);
    bus_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule